// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers the completion and resource events of a graphics engine into one interrupt line. It watches three sources. Two of them are one-cycle event pulses, frame rendered and binner flushed. They are caught in a pending register and stay there until software acknowledges them. The third is a level condition, binner out of memory. Its pending bit is forced on for as long as the condition lasts, so an acknowledge cannot remove it early.

Software reaches the block over a simple register bus. Pending bits are removed by writing ones to the status word. A pair of enable words adjusts the enable mask by single bits: one word sets bits, the other removes them, and zero bits in either write do nothing. This lets a handler mask the out-of-memory source alone while it supplies new memory, then unmask it again without touching the other two sources. Both enable words read back the same mask.

The interrupt output is a registered OR of the pending bits that are also enabled.

Top module: `gfx_irq_ctl`

## Requirements
- R1: After synchronous reset, the status word, the enable mask and `irq` are all zero.
- R2: A write to byte address 0x0 (status) clears each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to byte address 0x4 (enable-set) turns on each enable bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R4: A write to byte address 0x8 (enable-clear) turns off each enable bit whose data bit is 1. Zero data bits leave the mask unchanged.
- R5: Reads of 0x4 and of 0x8 both return the enable mask in bits 2:0. Bits 31:3 of every register read as zero.
- R6: A one-cycle pulse on `src_in[0]` (frame done) or `src_in[1]` (flush done) sets pending bit 0 or bit 1 in the next cycle. The bit then stays set until an R2 clear.
- R7: While `src_in[2]` (out-of-memory level) is high, pending bit 2 reads 1 even after a clear write. Once the level is low, a clear write removes the bit.
- R8: `irq` equals the OR of (pending AND enable) as it stood one clock earlier. It therefore changes one cycle after the status or mask changes.
- R9: If an event and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R10: Any other address reads as zero, and a write to it changes neither the status word nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| src_in | input | 3 | Sources: bit0 frame-done pulse, bit1 flush-done pulse, bit2 out-of-memory level |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 4-bit byte address and a 32-bit data word. The 4-bit address gives four word slots. Three of them hold the status word and the two enable words, so the one spare slot at 0xC covers the unmapped-address case. The 32-bit word leaves 29 upper data bits that must read as zero even when they are written as ones. The directed scenarios cover these cases:
- the out-of-memory handler sequence, which masks only that source and later unmasks it;
- the collision between an event and a clear write on the same bit;
- the one-cycle delay of the interrupt line, sampled on both sides of the edge where it changes.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC      = 3;
    localparam int BIT_FRAME = 0;
    localparam int BIT_FLUSH = 1;
    localparam int BIT_OOM   = 2;

    localparam int unsigned ADR_STATUS = 32'h0;
    localparam int unsigned ADR_EN_SET = 32'h4;
    localparam int unsigned ADR_EN_CLR = 32'h8;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     st_clr;
        logic     en_set;
        logic     en_clr;
        src_vec_t bits;
    } wr_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [31:0] byte_addr);
        case (byte_addr)
            ADR_STATUS: return SEL_STATUS;
            ADR_EN_SET: return SEL_EN_SET;
            ADR_EN_CLR: return SEL_EN_CLR;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  src_vec_t          status,
    input  src_vec_t          enable,
    output wr_cmd_t           cmd,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;

    always_comb begin
        sel        = decode_sel(32'(bus_addr));
        cmd.bits   = bus_wdata[NSRC-1:0];
        cmd.st_clr = bus_we && (sel == SEL_STATUS);
        cmd.en_set = bus_we && (sel == SEL_EN_SET);
        cmd.en_clr = bus_we && (sel == SEL_EN_CLR);
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_STATUS:             bus_rdata[NSRC-1:0] = status;
            SEL_EN_SET, SEL_EN_CLR: bus_rdata[NSRC-1:0] = enable;
            default:                bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
    import irq_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src_in,
    input  logic     clr_we,
    input  src_vec_t clr_bits,
    output src_vec_t status
);
    // Each bit is set by its source and cleared by a write of one.
    // The source term comes first, so it wins a same-cycle clear.
    // A level source that is still high therefore sets its bit again.
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic hold;
        assign hold = status[i] & ~(clr_we & clr_bits[i]);
        always_ff @(posedge clk) begin
            if (rst) status[i] <= 1'b0;
            else     status[i] <= src_in[i] | hold;
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_cmd_t  cmd,
    output src_vec_t enable
);
    always_ff @(posedge clk) begin
        if (rst)             enable <= '0;
        else if (cmd.en_set) enable <= enable | cmd.bits;
        else if (cmd.en_clr) enable <= enable & ~cmd.bits;
    end
endmodule

// File: rtl/gfx_irq_ctl.sv
module gfx_irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [2:0]        src_in,
    output logic              irq
);
    src_vec_t status_q;
    src_vec_t enable_q;
    wr_cmd_t  cmd;

    irq_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .status   (status_q),
        .enable   (enable_q),
        .cmd      (cmd),
        .bus_rdata(bus_rdata)
    );

    irq_pending_bank u_pend (
        .clk     (clk),
        .rst     (rst),
        .src_in  (src_in),
        .clr_we  (cmd.st_clr),
        .clr_bits(cmd.bits),
        .status  (status_q)
    );

    irq_enable_reg u_en (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .enable(enable_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status_q & enable_q);
    end
endmodule

// File: rtl/gfx_irq_ctl_chk.sv
module gfx_irq_ctl_chk
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [2:0]        src_in,
    input src_vec_t          status,
    input src_vec_t          enable,
    input logic              irq
);
    logic wr_st, wr_set, wr_clr;
    assign wr_st  = bus_we && (bus_addr == ADDR_W'(ADR_STATUS));
    assign wr_set = bus_we && (bus_addr == ADDR_W'(ADR_EN_SET));
    assign wr_clr = bus_we && (bus_addr == ADDR_W'(ADR_EN_CLR));

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (status == '0 && enable == '0 && irq == 1'b0));

    assert_w1c_frame_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_st && bus_wdata[BIT_FRAME] && !src_in[BIT_FRAME]) |=> !status[BIT_FRAME]);

    assert_enable_set_R3: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((enable & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    assert_enable_clear_R4: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((enable & $past(bus_wdata[NSRC-1:0])) == '0));

    assert_event_latch_R6: assert property (@(posedge clk) disable iff (rst)
        src_in[BIT_FLUSH] |=> status[BIT_FLUSH]);

    assert_oom_level_R7: assert property (@(posedge clk) disable iff (rst)
        src_in[BIT_OOM] |=> status[BIT_OOM]);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(status & enable))));

    assert_event_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (src_in[BIT_FRAME] && wr_st && bus_wdata[BIT_FRAME]) |=> status[BIT_FRAME]);
endmodule

bind gfx_irq_ctl gfx_irq_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .src_in   (src_in),
    .status   (status_q),
    .enable   (enable_q),
    .irq      (irq)
);

// File: tb/gfx_irq_ctl_test.sv
module gfx_irq_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [3:0] A_ST = 4'h0, A_SET = 4'h4, A_CLR = 4'h8, A_SPARE = 4'hC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [2:0]        src_in = '0;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    gfx_irq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_in[idx] = 1'b1;
        @(negedge clk);
        src_in[idx] = 1'b0;
    endtask

    task automatic clean();
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_write(A_ST, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        bus_read(A_ST, d);  check("R1 status", d, 0);
        bus_read(A_SET, d); check("R1 enable", d, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        clean();
        bus_write(A_SET, 32'hFFFF_FFF9);
        bus_read(A_SET, d); check("R3 set ones; R5 upper zero", d, 32'h1);
        bus_write(A_SET, 32'h4);
        bus_read(A_SET, d); check("R3 zeros ignored", d, 32'h5);
        bus_write(A_SET, 32'h0);
        bus_read(A_CLR, d); check("R5 clear addr reads mask", d, 32'h5);
        bus_write(A_CLR, 32'h1);
        bus_read(A_SET, d); check("R4 clear one bit", d, 32'h4);
        bus_write(A_CLR, 32'h0);
        bus_read(A_CLR, d); check("R4 zeros ignored", d, 32'h4);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        clean();
        pulse(0);
        bus_read(A_ST, d); check("R6 frame latched", d, 32'h1);
        pulse(1);
        repeat (2) @(negedge clk);
        bus_read(A_ST, d); check("R6 flush held", d, 32'h3);
        bus_write(A_ST, 32'h2);
        bus_read(A_ST, d); check("R2 clear bit1 only", d, 32'h1);
        bus_write(A_ST, 32'h0);
        bus_read(A_ST, d); check("R2 zero write no effect", d, 32'h1);
        bus_write(A_ST, 32'h1);
        bus_read(A_ST, d); check("R2 clear bit0", d, 32'h0);
    endtask

    task automatic t_irq_timing();
        clean();
        bus_write(A_SET, 32'h1);
        check("R8 irq idle", 32'(irq), 0);
        pulse(0);
        check("R8 irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R8 irq one cycle later", 32'(irq), 1);
        bus_write(A_ST, 32'h1);
        check("R8 irq still high after clear edge", 32'(irq), 1);
        @(negedge clk);
        check("R8 irq drops", 32'(irq), 0);
        pulse(1);
        repeat (2) @(negedge clk);
        check("R8 masked source no irq", 32'(irq), 0);
    endtask

    task automatic t_oom();
        logic [31:0] d;
        clean();
        bus_write(A_SET, 32'h7);
        @(negedge clk);
        src_in[2] = 1'b1;
        @(negedge clk);
        bus_read(A_ST, d); check("R7 oom pending", d, 32'h4);
        bus_write(A_ST, 32'h4);
        bus_read(A_ST, d); check("R7 ack while level high", d, 32'h4);
        bus_write(A_CLR, 32'h4);
        bus_read(A_SET, d); check("R4 only oom masked", d, 32'h3);
        @(negedge clk);
        check("R8 irq off when oom masked", 32'(irq), 0);
        src_in[2] = 1'b0;
        @(negedge clk);
        bus_write(A_ST, 32'h4);
        bus_read(A_ST, d); check("R7 cleared after level low", d, 32'h0);
        bus_write(A_SET, 32'h4);
        bus_read(A_CLR, d); check("R3 oom re-enabled", d, 32'h7);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        clean();
        @(negedge clk);
        src_in[1] = 1'b1; bus_addr = A_ST; bus_wdata = 32'h2; bus_we = 1'b1;
        @(negedge clk);
        src_in[1] = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        bus_read(A_ST, d); check("R9 event beats clear", d, 32'h2);
    endtask

    task automatic t_spare();
        logic [31:0] d;
        clean();
        pulse(0);
        bus_write(A_SET, 32'h2);
        bus_write(A_SPARE, 32'hFFFF_FFFF);
        bus_read(A_SPARE, d); check("R10 spare reads zero", d, 0);
        bus_read(A_ST, d);    check("R10 status untouched", d, 32'h1);
        bus_read(A_SET, d);   check("R10 mask untouched", d, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_latch();
        t_irq_timing();
        t_oom();
        t_collision();
        t_spare();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule